// File: doc/BRIEF.md
# Packet Rule Engine Sequencer

This block is the program-counter and issue control of a small packet-filtering rule engine. It sits idle at instruction zero until a packet begins. It then issues one instruction per cycle from a program of `PROG_LEN` slots. The executor answers each issued instruction in the same cycle with jump, accept, reject or limit-drop requests, and it reports which base registers that instruction writes. The sequencer turns those answers into the next program-counter value, pipeline bubbles and a final verdict.

Jumps only move forward, by a relative offset. A taken jump costs one empty issue slot while the pipeline refills. An instruction that reads packet data through a base register that the previous instruction has just written is held back for one cycle, so that its operand can be fetched again. If the program runs past its last slot with no decision, it starts again from slot zero. This repeats until the packet ends. A packet that ends with no decision gets a default reject.

Top module: `pkt_rule_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pc` is 0, `issue_valid` is 0 and `verdict_valid` is 0.
- R2: When idle, the block holds `pc` at 0 with `issue_valid` low. A `pkt_start` pulse makes instruction 0 issue in the next cycle.
- R3: An issued instruction that makes no jump and no decision is followed by an issue at `pc`+1 in the next cycle. After slot `PROG_LEN`-1 the next issue is at slot 0, and this continues until a verdict.
- R4: A jump request issued at slot p with `jump_off` k in 2..15 gives `pc`=p+k with `issue_valid` low in the next cycle, then an issue at p+k. A target of `PROG_LEN` or more gives 0. An offset of 0 or 1 is treated as a plain step with no bubble.
- R5: If the previous issued instruction wrote a base register (`base_wr`), and the instruction at `pc` has `uses_pkt`=1 and sets the same bit in `base_use`, then `issue_valid` is low for exactly one cycle and the same `pc` issues in the next cycle. With no common bit, or with `uses_pkt`=0, it issues at once.
- R6: A decision on an issued instruction gives a one-cycle `verdict_valid` pulse in the next cycle, with `pc` back at 0 and the block idle. The `verdict` codes are 01 for accept, 10 for reject and 11 for limit drop. Limit drop takes priority over reject, reject over accept, and any decision over a jump. `verdict` is 00 when no pulse is present.
- R7: `pkt_end` while evaluating, with no decision in that cycle, gives a reject verdict (10). If the issued instruction decides in the same cycle, its own verdict is reported instead.
- R8: `pkt_start` while a packet is being evaluated is ignored: issue continues at the next slot.
- R9: Requests are ignored in cycles with `issue_valid` low (bubbles, stalls, idle), and `pkt_end` is ignored when idle. Neither produces a verdict nor moves `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_start | input | 1 | A new packet begins |
| pkt_end | input | 1 | The current packet has ended |
| jump_req | input | 1 | Issued instruction requests a forward jump |
| jump_off | input | OFF_W | Relative jump offset |
| accept_req | input | 1 | Issued instruction accepts the packet |
| reject_req | input | 1 | Issued instruction rejects the packet |
| drop_req | input | 1 | Issued instruction drops the packet on an exhausted limit |
| base_wr | input | BASE_N | Base registers written by the issued instruction |
| uses_pkt | input | 1 | Instruction at `pc` reads packet data |
| base_use | input | BASE_N | Base registers referenced by the instruction at `pc` |
| pc | output | PC_W | Program counter |
| issue_valid | output | 1 | Instruction at `pc` issues this cycle |
| verdict_valid | output | 1 | One-cycle verdict pulse |
| verdict | output | 2 | Verdict code (01 accept, 10 reject, 11 drop) |

## Verification
Several functions can fall in the same cycle. The bench pairs the end of a packet with an accept on the issued instruction and expects accept rather than the default reject. It pairs a limit drop with an accept and a jump, and expects 11 with `pc` at 0 and no bubble. It pairs a reject with a jump, and expects the reject to end the packet. It also places an accept inside a jump bubble, where the accept must have no effect, and checks that no verdict appears and that the jump target still issues.

// File: rtl/prs_pkg.sv
package prs_pkg;

  typedef enum logic [1:0] {
    V_NONE   = 2'b00,
    V_ACCEPT = 2'b01,
    V_REJECT = 2'b10,
    V_DROP   = 2'b11
  } verdict_t;

  function automatic int unsigned step_pc(int unsigned cur, int unsigned len);
    return (cur + 1 >= len) ? 0 : cur + 1;
  endfunction

  function automatic int unsigned jump_pc(int unsigned cur, int unsigned off,
                                          int unsigned len);
    if (off < 2) return step_pc(cur, len);
    return (cur + off >= len) ? 0 : cur + off;
  endfunction

  function automatic verdict_t pick_verdict(logic drop, logic rej, logic acc);
    if (drop) return V_DROP;
    if (rej)  return V_REJECT;
    if (acc)  return V_ACCEPT;
    return V_NONE;
  endfunction

endpackage

// File: rtl/prs_hazard.sv
module prs_hazard #(
  parameter int BASE_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [BASE_N-1:0] base_wr,
  input  logic              uses_pkt,
  input  logic [BASE_N-1:0] base_use,
  output logic              hazard
);
  logic [BASE_N-1:0] wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= '0;
    else        wr_q <= issue ? base_wr : '0;
  end

  assign hazard = uses_pkt && (|(wr_q & base_use));

  // A stall never lasts beyond one cycle
  p_stall_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |=> !hazard);
endmodule

// File: rtl/prs_pc_calc.sv
module prs_pc_calc #(
  parameter int PROG_LEN = 16,
  parameter int PC_W     = 4,
  parameter int OFF_W    = 4
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  logic             jump_req,
  input  logic [OFF_W-1:0] jump_off,
  output logic             jump_real,
  output logic [PC_W-1:0]  pc_nxt
);
  import prs_pkg::*;

  assign jump_real = jump_req && (jump_off >= OFF_W'(2));

  always_comb begin
    if (jump_req)
      pc_nxt = PC_W'(jump_pc(int'(pc_cur), int'(jump_off), PROG_LEN));
    else
      pc_nxt = PC_W'(step_pc(int'(pc_cur), PROG_LEN));
  end
endmodule

// File: rtl/prs_verdict.sv
module prs_verdict (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       issue,
  input  logic       drop_req,
  input  logic       reject_req,
  input  logic       accept_req,
  input  logic       pkt_end,
  output logic       done,
  output logic       verdict_valid,
  output logic [1:0] verdict
);
  import prs_pkg::*;

  logic     decide_evt;
  logic     end_evt;
  verdict_t code_q;

  assign decide_evt = issue && (drop_req || reject_req || accept_req);
  assign end_evt    = run && pkt_end && !decide_evt;
  assign done       = decide_evt || end_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid <= 1'b0;
      code_q        <= V_NONE;
    end else begin
      verdict_valid <= done;
      if (decide_evt)   code_q <= pick_verdict(drop_req, reject_req, accept_req);
      else if (end_evt) code_q <= V_REJECT;
      else              code_q <= V_NONE;
    end
  end

  assign verdict = code_q;

  p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |=> !verdict_valid);
  p_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (verdict != 2'b00));
  p_default_rej_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (verdict == 2'b10));
endmodule

// File: rtl/pkt_rule_seq.sv
module pkt_rule_seq #(
  parameter int PROG_LEN = 16,
  parameter int OFF_W    = 4,
  parameter int BASE_N   = 4,
  localparam int PC_W    = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              pkt_end,
  input  logic              jump_req,
  input  logic [OFF_W-1:0]  jump_off,
  input  logic              accept_req,
  input  logic              reject_req,
  input  logic              drop_req,
  input  logic [BASE_N-1:0] base_wr,
  input  logic              uses_pkt,
  input  logic [BASE_N-1:0] base_use,
  output logic [PC_W-1:0]   pc,
  output logic              issue_valid,
  output logic              verdict_valid,
  output logic [1:0]        verdict
);
  import prs_pkg::*;

  logic            run_q;
  logic            bubble_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic            hazard;
  logic            jump_real;
  logic            done;
  logic [PC_W-1:0] pc_step;

  assign issue_valid = run_q && !bubble_q && !hazard;
  assign pc          = pc_q;
  assign pc_step     = PC_W'(step_pc(int'(pc_q), PROG_LEN));

  prs_hazard #(.BASE_N(BASE_N)) u_haz (
    .clk(clk), .rst_n(rst_n), .issue(issue_valid), .base_wr(base_wr),
    .uses_pkt(uses_pkt), .base_use(base_use), .hazard(hazard)
  );

  prs_pc_calc #(.PROG_LEN(PROG_LEN), .PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
    .pc_cur(pc_q), .jump_req(jump_req), .jump_off(jump_off),
    .jump_real(jump_real), .pc_nxt(pc_nxt)
  );

  prs_verdict u_vd (
    .clk(clk), .rst_n(rst_n), .run(run_q), .issue(issue_valid),
    .drop_req(drop_req), .reject_req(reject_req), .accept_req(accept_req),
    .pkt_end(pkt_end), .done(done), .verdict_valid(verdict_valid),
    .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      bubble_q <= 1'b0;
      pc_q     <= '0;
    end else if (!run_q) begin
      run_q    <= pkt_start;
      bubble_q <= 1'b0;
      pc_q     <= '0;
    end else if (done) begin
      run_q    <= 1'b0;
      bubble_q <= 1'b0;
      pc_q     <= '0;
    end else if (issue_valid) begin
      pc_q     <= pc_nxt;
      bubble_q <= jump_real;
    end else begin
      bubble_q <= 1'b0;
    end
  end

  p_start_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (pc_q == '0));
  p_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !jump_req && !done) |=> (pc_q == $past(pc_step)));
  p_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && jump_real && !done) |=> !issue_valid);
  p_stall_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && hazard && !done) |=> (issue_valid && $stable(pc_q)));
  p_idle_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> (!run_q && pc_q == '0));
  p_keep_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done) |=> run_q);
endmodule

// File: tb/sim_pkt_rule_seq.sv
`timescale 1ns/1ps
module sim_pkt_rule_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pkt_start = 0, pkt_end = 0, jump_req = 0;
  logic [3:0] jump_off = '0;
  logic       accept_req = 0, reject_req = 0, drop_req = 0;
  logic [3:0] base_wr = '0, base_use = '0;
  logic       uses_pkt = 0;
  logic [3:0] pc;
  logic       issue_valid, verdict_valid;
  logic [1:0] verdict;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pkt_rule_seq u0 (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .pkt_end(pkt_end),
    .jump_req(jump_req), .jump_off(jump_off), .accept_req(accept_req),
    .reject_req(reject_req), .drop_req(drop_req), .base_wr(base_wr),
    .uses_pkt(uses_pkt), .base_use(base_use), .pc(pc),
    .issue_valid(issue_valid), .verdict_valid(verdict_valid), .verdict(verdict)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    pkt_start = 0; pkt_end = 0; jump_req = 0; jump_off = '0;
    accept_req = 0; reject_req = 0; drop_req = 0; base_wr = '0;
  endtask

  task automatic cyc();
    @(negedge clk);
    clr();
    #1;
  endtask

  task automatic start_pkt();
    pkt_start = 1;
    cyc();
  endtask

  task automatic t_reset();
    #1;
    chk("R1 pc", int'(pc), 0);
    chk("R1 issue", int'(issue_valid), 0);
    chk("R1 vvalid", int'(verdict_valid), 0);
    rst_n = 1;
    cyc();
    chk("R1 pc after release", int'(pc), 0);
    chk("R1 vvalid after release", int'(verdict_valid), 0);
  endtask

  task automatic t_run_and_wrap();
    repeat (3) begin
      cyc();
      chk("R2 idle issue", int'(issue_valid), 0);
    end
    start_pkt();
    chk("R2 first pc", int'(pc), 0);
    chk("R2 first issue", int'(issue_valid), 1);
    for (int i = 1; i <= 17; i++) begin
      cyc();
      chk("R3 step pc", int'(pc), i % 16);
      chk("R3 step issue", int'(issue_valid), 1);
    end
    accept_req = 1;
    cyc();
    chk("R6 accept pulse", int'(verdict_valid), 1);
    chk("R6 accept code", int'(verdict), 1);
    chk("R6 pc zero", int'(pc), 0);
    chk("R6 idle issue", int'(issue_valid), 0);
    cyc();
    chk("R6 single pulse", int'(verdict_valid), 0);
    chk("R6 code cleared", int'(verdict), 0);
  endtask

  task automatic t_jump();
    start_pkt();
    jump_req = 1; jump_off = 4'd5;
    cyc();
    chk("R4 jump pc", int'(pc), 5);
    chk("R4 bubble", int'(issue_valid), 0);
    accept_req = 1;
    cyc();
    chk("R9 accept in bubble no verdict", int'(verdict_valid), 0);
    chk("R4 target issues", int'(issue_valid), 1);
    chk("R9 pc kept", int'(pc), 5);
    jump_req = 1; jump_off = 4'd13;
    cyc();
    chk("R4 wrap pc", int'(pc), 0);
    chk("R4 wrap bubble", int'(issue_valid), 0);
    cyc();
    chk("R4 wrap issue", int'(issue_valid), 1);
    jump_req = 1; jump_off = 4'd1;
    cyc();
    chk("R4 small offset pc", int'(pc), 1);
    chk("R4 small offset no bubble", int'(issue_valid), 1);
    reject_req = 1;
    cyc();
    chk("R6 reject code", int'(verdict), 2);
    chk("R6 reject pulse", int'(verdict_valid), 1);
  endtask

  task automatic t_hazard();
    cyc();
    start_pkt();
    base_wr = 4'b0010;
    @(negedge clk); clr(); uses_pkt = 1; base_use = 4'b0010; #1;
    chk("R5 stall pc", int'(pc), 1);
    chk("R5 stall issue", int'(issue_valid), 0);
    cyc();
    chk("R5 resume pc", int'(pc), 1);
    chk("R5 resume issue", int'(issue_valid), 1);
    base_wr = 4'b0001;
    cyc();
    chk("R5 disjoint pc", int'(pc), 2);
    chk("R5 disjoint issue", int'(issue_valid), 1);
    base_wr = 4'b0100;
    @(negedge clk); clr(); uses_pkt = 0; base_use = 4'b0100; #1;
    chk("R5 no packet data pc", int'(pc), 3);
    chk("R5 no packet data issue", int'(issue_valid), 1);
    drop_req = 1; accept_req = 1; jump_req = 1; jump_off = 4'd3;
    cyc();
    chk("R6 drop priority code", int'(verdict), 3);
    chk("R6 drop pc", int'(pc), 0);
    base_use = '0;
  endtask

  task automatic t_end_and_restart();
    cyc();
    start_pkt();
    cyc();
    pkt_start = 1;
    cyc();
    chk("R8 start ignored pc", int'(pc), 2);
    chk("R8 start ignored issue", int'(issue_valid), 1);
    pkt_end = 1;
    cyc();
    chk("R7 default reject pulse", int'(verdict_valid), 1);
    chk("R7 default reject code", int'(verdict), 2);
    chk("R7 idle pc", int'(pc), 0);
    start_pkt();
    pkt_end = 1; accept_req = 1;
    cyc();
    chk("R7 end with accept code", int'(verdict), 1);
    start_pkt();
    reject_req = 1; jump_req = 1; jump_off = 4'd4;
    cyc();
    chk("R6 reject over jump code", int'(verdict), 2);
    chk("R6 reject over jump pc", int'(pc), 0);
    cyc();
    chk("R6 reject over jump idle", int'(issue_valid), 0);
  endtask

  task automatic t_idle_ignore();
    pkt_end = 1; accept_req = 1;
    cyc();
    chk("R9 idle end no verdict", int'(verdict_valid), 0);
    chk("R9 idle no issue", int'(issue_valid), 0);
    chk("R9 idle pc", int'(pc), 0);
  endtask

  initial begin
    t_reset();
    t_run_and_wrap();
    t_jump();
    t_hazard();
    t_end_and_restart();
    t_idle_ignore();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule